// File: doc/BRIEF.md
# Receive Buffer Descriptor Sequencer

This block walks a ring of receive buffer descriptors and turns a stream of received bytes into 16-bit buffer writes. A descriptor pointer selects the descriptor in use. While no frame is in progress it names the next descriptor to be filled, and during reception it stays on the descriptor being filled. The descriptor memory is outside the block. For the descriptor at the pointer, that memory returns the empty flag, the wrap (end-of-table) flag and the buffer start address, with a combinational read.

Accepted bytes are paired into 16-bit words, and a configuration bit selects which half of the word takes the earlier byte. Each word goes out on a single-cycle write request port to the descriptor's buffer. When the byte count reaches a programmed maximum, the buffer closes. A status word with the empty flag cleared is then written back to the descriptor. The pointer then moves 8 bytes on, or returns to the programmed base address if the descriptor carries the wrap flag. Every request carries a 4-bit function code from the configuration register. One code value is illegal: it is flagged, and no request is issued while it is set.

Top module: `rxbd_seq`

## Requirements
- R1: After reset, `bd_ptr` equals the base reset value 0x0100, `wr_req` is 0, `rx_active` is 0, and `cfg_rdata` reads 0x18 (byte order 1, function code 1000).
- R2: `cfg_rdata` bits 7:5 always read 0. Bit 4 is the byte-order select, and bits 3:0 are the function code, both taken from the last `cfg_wdata` written with `cfg_we`.
- R3: With byte order 1, byte k (k odd, counting from 0 in the buffer) and byte k-1 form one word. Byte k-1 goes in bits 15:8 and byte k in bits 7:0. The word is written at `bd_buf_addr + (k-1)`, and `wr_req` is high in the cycle after byte k is accepted.
- R4: With byte order 0, the placement is reversed: the earlier byte goes in bits 7:0 and the later byte in bits 15:8.
- R5: When the accepted byte count reaches `maxlen`, the cycle after the last data write carries a status write. Its address is the descriptor address, and its data is bit 15 = 0 (empty cleared), bit 14 = the descriptor's wrap flag, bits 7:0 = byte count, and all other bits 0. In that same cycle `bd_ptr` shows the old pointer plus 8.
- R6: If the buffer closes after an odd number of bytes, the last byte is written as a word in the cycle after it is accepted. The unused half of that word is zero.
- R7: When the closing descriptor has its wrap flag set, the pointer is reloaded from the base register instead of being incremented. A base write forces bits 2:0 to zero.
- R8: A pointer write (`ptr_we`) with `rx_en` low sets `bd_ptr` in the next cycle, with bits 2:0 forced to zero. With `rx_en` high the write is ignored.
- R9: `rx_valid` is ignored while `rx_en` is low, while no frame is active and the descriptor is not empty, and in the status-write cycle of a close.
- R10: `wr_fc` carries the configured function code. While that code is 0111, `fc_fault` is high and no `wr_req` is raised. Byte counting and pointer movement continue.
- R11: `rx_active` is high from the cycle after a frame's first byte until the status write, and `bd_ptr` holds the current descriptor throughout the frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_en | input | 1 | Receiver enable |
| cfg_we | input | 1 | Configuration register write strobe |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_rdata | output | 8 | Configuration readback |
| base_we | input | 1 | Base address write strobe |
| base_wdata | input | 16 | Base address write data |
| ptr_we | input | 1 | Descriptor pointer write strobe |
| ptr_wdata | input | 16 | Descriptor pointer write data |
| maxlen_we | input | 1 | Maximum buffer length write strobe |
| maxlen_wdata | input | 8 | Maximum buffer length in bytes |
| rx_valid | input | 1 | Received byte strobe |
| rx_data | input | 8 | Received byte |
| bd_ptr | output | 16 | Descriptor pointer (descriptor read address) |
| bd_empty | input | 1 | Empty flag of the descriptor at `bd_ptr` |
| bd_wrap | input | 1 | Wrap flag of the descriptor at `bd_ptr` |
| bd_buf_addr | input | 16 | Buffer start address of the descriptor at `bd_ptr` |
| wr_req | output | 1 | Memory write request, one cycle per write |
| wr_addr | output | 16 | Write byte address |
| wr_data | output | 16 | Write data |
| wr_fc | output | 4 | Function code of the access |
| fc_fault | output | 1 | Illegal function code configured |
| rx_active | output | 1 | Frame in progress or closing |

## Verification
A data word is due one cycle after the byte that completes it, or after the last byte of an odd-length buffer. The status write and the new pointer value are due one cycle later still. The driver places each byte for exactly one cycle and pushes the writes it expects before driving. The monitor samples at the falling edge and pairs each request with the oldest expected item, so any write that arrives a cycle early or late, or in the wrong order, shows up as a mismatch. Pointer, activity and fault outputs are sampled at the falling edge after the cycle in which they are due.

// File: rtl/rxbd_pkg.sv
package rxbd_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RECV  = 2'd1,
    ST_CLOSE = 2'd2
  } seq_state_e;

  typedef struct packed {
    logic       hi_first;
    logic [3:0] fc;
  } cfg_t;

  localparam logic [3:0] FC_ILLEGAL = 4'b0111;
  localparam int unsigned WORD_W    = 16;
  localparam int unsigned BYTE_W    = 8;
endpackage

// File: rtl/rxbd_cfg.sv
module rxbd_cfg
  import rxbd_pkg::*;
#(
  parameter int unsigned AW          = 16,
  parameter int unsigned LW          = 8,
  parameter int unsigned STEP        = 8,
  parameter logic [15:0] BASE_INIT   = 16'h0100,
  parameter logic [7:0]  MAXLEN_INIT = 8'd4,
  parameter logic [7:0]  CFG_INIT    = 8'h18
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [7:0]    cfg_wdata,
  input  logic          base_we,
  input  logic [AW-1:0] base_wdata,
  input  logic          maxlen_we,
  input  logic [LW-1:0] maxlen_wdata,
  output cfg_t          cfg_q,
  output logic [AW-1:0] base_q,
  output logic [LW-1:0] maxlen_q,
  output logic [7:0]    cfg_rdata,
  output logic          fc_bad
);
  localparam int unsigned SH = $clog2(STEP);

  cfg_t          cfg_d;
  logic [AW-1:0] base_d;
  logic [LW-1:0] maxlen_d;

  always_comb begin
    cfg_d    = cfg_q;
    base_d   = base_q;
    maxlen_d = maxlen_q;
    if (cfg_we) begin
      cfg_d.hi_first = cfg_wdata[4];
      cfg_d.fc       = cfg_wdata[3:0];
    end
    if (base_we) begin
      base_d = {base_wdata[AW-1:SH], {SH{1'b0}}};
    end
    if (maxlen_we) begin
      maxlen_d = maxlen_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q.hi_first <= CFG_INIT[4];
      cfg_q.fc       <= CFG_INIT[3:0];
      base_q         <= AW'(BASE_INIT);
      maxlen_q       <= LW'(MAXLEN_INIT);
    end else begin
      cfg_q    <= cfg_d;
      base_q   <= base_d;
      maxlen_q <= maxlen_d;
    end
  end

  assign cfg_rdata = {3'b000, cfg_q.hi_first, cfg_q.fc};
  assign fc_bad    = (cfg_q.fc == FC_ILLEGAL);
endmodule

// File: rtl/rxbd_ptr.sv
module rxbd_ptr #(
  parameter int unsigned AW        = 16,
  parameter int unsigned STEP      = 8,
  parameter logic [15:0] BASE_INIT = 16'h0100
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          advance,
  input  logic          wrap,
  input  logic [AW-1:0] base,
  input  logic          host_we,
  input  logic [AW-1:0] host_data,
  input  logic          rx_en,
  output logic [AW-1:0] ptr_q
);
  localparam int unsigned SH = $clog2(STEP);

  logic [AW-1:0] ptr_d;
  logic          ptr_en;

  always_comb begin
    ptr_en = 1'b0;
    ptr_d  = ptr_q;
    if (advance) begin
      ptr_en = 1'b1;
      ptr_d  = wrap ? base : ptr_q + AW'(STEP);
    end else if (host_we && !rx_en) begin
      ptr_en = 1'b1;
      ptr_d  = {host_data[AW-1:SH], {SH{1'b0}}};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= AW'(BASE_INIT);
    end else if (ptr_en) begin
      ptr_q <= ptr_d;
    end
  end
endmodule

// File: rtl/rxbd_pack.sv
module rxbd_pack #(
  parameter int unsigned AW = 16,
  parameter int unsigned LW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          accept,
  input  logic [7:0]    byte_in,
  input  logic          hi_first,
  input  logic [LW-1:0] maxlen,
  input  logic [AW-1:0] buf_addr,
  input  logic          clear,
  output logic          word_valid,
  output logic [AW-1:0] word_addr,
  output logic [15:0]   word_data,
  output logic          last,
  output logic [LW-1:0] count
);
  logic [LW-1:0] cnt_q, cnt_d;
  logic [7:0]    hold_q, hold_d;
  logic [7:0]    early, late;
  logic          odd_pos;

  assign odd_pos = cnt_q[0];
  assign last    = ((cnt_q + LW'(1)) == maxlen);

  always_comb begin
    if (odd_pos) begin
      early = hold_q;
      late  = byte_in;
    end else begin
      early = byte_in;
      late  = 8'h00;
    end
    word_data  = hi_first ? {early, late} : {late, early};
    word_addr  = buf_addr + AW'({cnt_q[LW-1:1], 1'b0});
    word_valid = accept && (odd_pos || last);
  end

  always_comb begin
    cnt_d  = cnt_q;
    hold_d = hold_q;
    if (clear) begin
      cnt_d = '0;
    end else if (accept) begin
      cnt_d = cnt_q + LW'(1);
      if (!odd_pos) hold_d = byte_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      hold_q <= '0;
    end else begin
      cnt_q  <= cnt_d;
      hold_q <= hold_d;
    end
  end

  assign count = cnt_q;
endmodule

// File: rtl/rxbd_seq.sv
module rxbd_seq
  import rxbd_pkg::*;
#(
  parameter int unsigned AW          = 16,
  parameter int unsigned LW          = 8,
  parameter int unsigned STEP        = 8,
  parameter logic [15:0] BASE_INIT   = 16'h0100,
  parameter logic [7:0]  MAXLEN_INIT = 8'd4,
  parameter logic [7:0]  CFG_INIT    = 8'h18
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rx_en,
  input  logic          cfg_we,
  input  logic [7:0]    cfg_wdata,
  output logic [7:0]    cfg_rdata,
  input  logic          base_we,
  input  logic [AW-1:0] base_wdata,
  input  logic          ptr_we,
  input  logic [AW-1:0] ptr_wdata,
  input  logic          maxlen_we,
  input  logic [LW-1:0] maxlen_wdata,
  input  logic          rx_valid,
  input  logic [7:0]    rx_data,
  output logic [AW-1:0] bd_ptr,
  input  logic          bd_empty,
  input  logic          bd_wrap,
  input  logic [AW-1:0] bd_buf_addr,
  output logic          wr_req,
  output logic [AW-1:0] wr_addr,
  output logic [15:0]   wr_data,
  output logic [3:0]    wr_fc,
  output logic          fc_fault,
  output logic          rx_active
);
  localparam int unsigned PAD_W = 14 - LW;

  cfg_t          cfg_q;
  logic [AW-1:0] base_q;
  logic [LW-1:0] maxlen_q;
  logic          fc_bad;

  seq_state_e    st_q, st_d;
  logic          accept, closing;

  logic          word_valid, last;
  logic [AW-1:0] word_addr;
  logic [15:0]   word_data;
  logic [LW-1:0] count;
  logic [15:0]   status_word;

  logic          req_d, req_q;
  logic [AW-1:0] addr_d, addr_q;
  logic [15:0]   data_d, data_q;
  logic [3:0]    fc_q;
  logic          out_en;

  rxbd_cfg #(
    .AW(AW), .LW(LW), .STEP(STEP), .BASE_INIT(BASE_INIT),
    .MAXLEN_INIT(MAXLEN_INIT), .CFG_INIT(CFG_INIT)
  ) u_cfg (
    .clk(clk), .rst_n(rst_n),
    .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .base_we(base_we), .base_wdata(base_wdata),
    .maxlen_we(maxlen_we), .maxlen_wdata(maxlen_wdata),
    .cfg_q(cfg_q), .base_q(base_q), .maxlen_q(maxlen_q),
    .cfg_rdata(cfg_rdata), .fc_bad(fc_bad)
  );

  assign closing = (st_q == ST_CLOSE);
  assign accept  = rx_valid && rx_en &&
                   (((st_q == ST_IDLE) && bd_empty) || (st_q == ST_RECV));

  rxbd_ptr #(.AW(AW), .STEP(STEP), .BASE_INIT(BASE_INIT)) u_ptr (
    .clk(clk), .rst_n(rst_n),
    .advance(closing), .wrap(bd_wrap), .base(base_q),
    .host_we(ptr_we), .host_data(ptr_wdata), .rx_en(rx_en),
    .ptr_q(bd_ptr)
  );

  rxbd_pack #(.AW(AW), .LW(LW)) u_pack (
    .clk(clk), .rst_n(rst_n),
    .accept(accept), .byte_in(rx_data), .hi_first(cfg_q.hi_first),
    .maxlen(maxlen_q), .buf_addr(bd_buf_addr), .clear(closing),
    .word_valid(word_valid), .word_addr(word_addr), .word_data(word_data),
    .last(last), .count(count)
  );

  generate
    if (PAD_W > 0) begin : g_pad
      assign status_word = {1'b0, bd_wrap, {PAD_W{1'b0}}, count};
    end else begin : g_nopad
      assign status_word = {1'b0, bd_wrap, count};
    end
  endgenerate

  always_comb begin
    st_d = st_q;
    case (st_q)
      ST_IDLE:  if (accept) st_d = last ? ST_CLOSE : ST_RECV;
      ST_RECV:  if (accept && last) st_d = ST_CLOSE;
      ST_CLOSE: st_d = ST_IDLE;
      default:  st_d = ST_IDLE;
    endcase
  end

  always_comb begin
    req_d  = 1'b0;
    addr_d = addr_q;
    data_d = data_q;
    if (closing) begin
      req_d  = 1'b1;
      addr_d = bd_ptr;
      data_d = status_word;
    end else if (word_valid) begin
      req_d  = 1'b1;
      addr_d = word_addr;
      data_d = word_data;
    end
    out_en = req_d;
    req_d  = req_d && !fc_bad;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      req_q <= 1'b0;
      fc_q  <= CFG_INIT[3:0];
    end else begin
      st_q  <= st_d;
      req_q <= req_d;
      fc_q  <= cfg_q.fc;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      data_q <= '0;
    end else if (out_en) begin
      addr_q <= addr_d;
      data_q <= data_d;
    end
  end

  assign wr_req    = req_q;
  assign wr_addr   = addr_q;
  assign wr_data   = data_q;
  assign wr_fc     = fc_q;
  assign fc_fault  = fc_bad;
  assign rx_active = (st_q != ST_IDLE);
endmodule

// File: rtl/rxbd_seq_chk.sv
module rxbd_seq_chk #(
  parameter int unsigned AW   = 16,
  parameter int unsigned STEP = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rx_en,
  input logic          ptr_we,
  input logic          rx_active,
  input logic          rx_valid,
  input logic          bd_empty,
  input logic [AW-1:0] bd_ptr,
  input logic [AW-1:0] base,
  input logic          wr_req,
  input logic [3:0]    wr_fc,
  input logic [7:0]    cfg_rdata
);
  a_r10_no_illegal_fc: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req |-> (wr_fc != 4'b0111));

  a_r2_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_rdata[7:5] == 3'b000);

  a_r8_ptr_locked: assert property (@(posedge clk) disable iff (!rst_n)
    (ptr_we && rx_en && !rx_active) |=> $stable(bd_ptr));

  a_r5_ptr_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    bd_ptr[2:0] == 3'b000);

  a_r7_ptr_moves: assert property (@(posedge clk) disable iff (!rst_n)
    (bd_ptr != $past(bd_ptr)) |->
      ((bd_ptr == $past(bd_ptr) + AW'(STEP)) || (bd_ptr == $past(base)) || !$past(rx_en)));

  a_r9_full_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (!rx_active && rx_valid && !bd_empty) |=> !rx_active);
endmodule

bind rxbd_seq rxbd_seq_chk #(.AW(AW), .STEP(STEP)) u_chk (
  .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .ptr_we(ptr_we),
  .rx_active(rx_active), .rx_valid(rx_valid), .bd_empty(bd_empty),
  .bd_ptr(bd_ptr), .base(base_q), .wr_req(wr_req), .wr_fc(wr_fc),
  .cfg_rdata(cfg_rdata)
);

// File: tb/rxbd_seq_test.sv
module rxbd_seq_test;
  logic        clk;
  logic        rst_n;
  logic        rx_en;
  logic        cfg_we;
  logic [7:0]  cfg_wdata;
  logic [7:0]  cfg_rdata;
  logic        base_we;
  logic [15:0] base_wdata;
  logic        ptr_we;
  logic [15:0] ptr_wdata;
  logic        maxlen_we;
  logic [7:0]  maxlen_wdata;
  logic        rx_valid;
  logic [7:0]  rx_data;
  logic [15:0] bd_ptr;
  logic        bd_empty;
  logic        bd_wrap;
  logic [15:0] bd_buf_addr;
  logic        wr_req;
  logic [15:0] wr_addr;
  logic [15:0] wr_data;
  logic [3:0]  wr_fc;
  logic        fc_fault;
  logic        rx_active;

  int total;
  int bad;
  bit done;

  logic [15:0] ptr_m, base_m, wrap_at;
  logic [7:0]  cnt_m, hold_m, maxlen_m;
  logic [3:0]  fc_m;
  bit          hi_m, en_m, full_m, closing_m;

  logic [35:0] expq[$];

  rxbd_seq uut (
    .clk(clk), .rst_n(rst_n), .rx_en(rx_en),
    .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .base_we(base_we), .base_wdata(base_wdata),
    .ptr_we(ptr_we), .ptr_wdata(ptr_wdata),
    .maxlen_we(maxlen_we), .maxlen_wdata(maxlen_wdata),
    .rx_valid(rx_valid), .rx_data(rx_data),
    .bd_ptr(bd_ptr), .bd_empty(bd_empty), .bd_wrap(bd_wrap), .bd_buf_addr(bd_buf_addr),
    .wr_req(wr_req), .wr_addr(wr_addr), .wr_data(wr_data), .wr_fc(wr_fc),
    .fc_fault(fc_fault), .rx_active(rx_active)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  assign bd_empty    = !full_m;
  assign bd_wrap     = (bd_ptr == wrap_at);
  assign bd_buf_addr = 16'h8000 | {bd_ptr[11:0], 4'h0};

  task automatic chk(input bit ok, input string tag, input logic [35:0] act, input logic [35:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: pop and compare every write request
  always @(negedge clk) begin
    if (rst_n && wr_req) begin
      if (expq.size() == 0) begin
        chk(1'b0, "R3/R10 unexpected write", {wr_fc, wr_addr, wr_data}, 36'h0);
      end else begin
        logic [35:0] e;
        e = expq.pop_front();
        chk({wr_fc, wr_addr, wr_data} == e, "R3/R4/R5/R6 write", {wr_fc, wr_addr, wr_data}, e);
      end
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
    closing_m = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] b);
    bit acc;
    acc = en_m && !closing_m && (cnt_m != 0 || !full_m);
    closing_m = 1'b0;
    if (acc) begin
      logic [7:0]  idx;
      logic [15:0] w;
      bit          lst;
      idx = cnt_m;
      lst = (cnt_m + 8'd1) == maxlen_m;
      if (idx[0] || lst) begin
        if (idx[0]) w = hi_m ? {hold_m, b} : {b, hold_m};
        else        w = hi_m ? {b, 8'h00} : {8'h00, b};
        if (fc_m != 4'b0111)
          expq.push_back({fc_m, 16'h8000 | {ptr_m[11:0], 4'h0} + {8'h00, idx[7:1], 1'b0}, w});
      end
      if (!idx[0]) hold_m = b;
      cnt_m = cnt_m + 8'd1;
      if (lst) begin
        if (fc_m != 4'b0111)
          expq.push_back({fc_m, ptr_m, 1'b0, (ptr_m == wrap_at), 6'b0, cnt_m});
        ptr_m     = (ptr_m == wrap_at) ? base_m : ptr_m + 16'd8;
        cnt_m     = 8'd0;
        closing_m = 1'b1;
      end
    end
    rx_valid = 1'b1;
    rx_data  = b;
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  task automatic write_cfg(input logic [7:0] v);
    cfg_we = 1'b1; cfg_wdata = v;
    @(negedge clk);
    cfg_we = 1'b0;
    hi_m = v[4]; fc_m = v[3:0];
    closing_m = 1'b0;
  endtask

  task automatic write_maxlen(input logic [7:0] v);
    maxlen_we = 1'b1; maxlen_wdata = v;
    @(negedge clk);
    maxlen_we = 1'b0; maxlen_m = v;
    closing_m = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    total = 0; bad = 0; done = 0;
    rst_n = 1'b0; rx_en = 1'b1; cfg_we = 0; cfg_wdata = 0; base_we = 0; base_wdata = 0;
    ptr_we = 0; ptr_wdata = 0; maxlen_we = 0; maxlen_wdata = 0; rx_valid = 0; rx_data = 0;
    ptr_m = 16'h0100; base_m = 16'h0100; wrap_at = 16'hFFF8; cnt_m = 0; hold_m = 0;
    maxlen_m = 8'd4; fc_m = 4'b1000; hi_m = 1; en_m = 1; full_m = 0; closing_m = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk(bd_ptr == 16'h0100, "R1 ptr", 36'(bd_ptr), 36'h0100);
    chk(wr_req == 1'b0, "R1 wr_req", 36'(wr_req), 36'h0);
    chk(rx_active == 1'b0, "R1 rx_active", 36'(rx_active), 36'h0);
    chk(cfg_rdata == 8'h18, "R1 cfg", 36'(cfg_rdata), 36'h18);

    // R2 reserved bits read zero
    write_cfg(8'hFF);
    chk(cfg_rdata == 8'h1F, "R2 cfg readback", 36'(cfg_rdata), 36'h1F);
    chk(fc_fault == 1'b0, "R10 fc 1111 legal", 36'(fc_fault), 36'h0);
    write_cfg(8'h18);

    // R3 order 1, R11 pointer holds during frame
    send_byte(8'hAA);
    chk(rx_active == 1'b1, "R11 active", 36'(rx_active), 36'h1);
    chk(bd_ptr == 16'h0100, "R11 ptr holds", 36'(bd_ptr), 36'h0100);
    send_byte(8'hBB); send_byte(8'hCC); send_byte(8'hDD);
    chk(bd_ptr == 16'h0100, "R5 ptr before status", 36'(bd_ptr), 36'h0100);
    idle(1);
    chk(bd_ptr == 16'h0108, "R5 ptr advanced", 36'(bd_ptr), 36'h0108);
    chk(rx_active == 1'b0, "R11 idle after close", 36'(rx_active), 36'h0);

    // R4 order 0
    write_cfg(8'h08);
    send_byte(8'h11); send_byte(8'h22); send_byte(8'h33); send_byte(8'h44);
    idle(2);

    // R6 odd length flush
    write_cfg(8'h18);
    write_maxlen(8'd3);
    send_byte(8'h55); send_byte(8'h66); send_byte(8'h77);
    idle(2);
    chk(bd_ptr == 16'h0118, "R6 ptr", 36'(bd_ptr), 36'h0118);

    // R9 byte during close ignored (back to back)
    send_byte(8'h01); send_byte(8'h02); send_byte(8'h03); send_byte(8'hEE);
    idle(1);
    send_byte(8'h04); send_byte(8'h05); send_byte(8'h06);
    idle(2);
    chk(bd_ptr == 16'h0128, "R9 close byte ignored", 36'(bd_ptr), 36'h0128);

    // R7 wrap to a newly programmed base
    base_we = 1'b1; base_wdata = 16'h0203;
    @(negedge clk);
    base_we = 1'b0; base_m = 16'h0200;
    wrap_at = 16'h0128;
    send_byte(8'h90); send_byte(8'h91); send_byte(8'h92);
    idle(2);
    chk(bd_ptr == 16'h0200, "R7 wrap to base", 36'(bd_ptr), 36'h0200);

    // R9 disabled receiver, R8 host pointer write
    rx_en = 1'b0; en_m = 0;
    send_byte(8'hC1); send_byte(8'hC2);
    chk(rx_active == 1'b0, "R9 disabled ignored", 36'(rx_active), 36'h0);
    ptr_we = 1'b1; ptr_wdata = 16'h0305;
    @(negedge clk);
    ptr_we = 1'b0; ptr_m = 16'h0300;
    chk(bd_ptr == 16'h0300, "R8 write while disabled", 36'(bd_ptr), 36'h0300);
    rx_en = 1'b1; en_m = 1;
    ptr_we = 1'b1; ptr_wdata = 16'h0400;
    @(negedge clk);
    ptr_we = 1'b0;
    idle(1);
    chk(bd_ptr == 16'h0300, "R8 write while enabled ignored", 36'(bd_ptr), 36'h0300);

    // R9 descriptor not empty
    full_m = 1;
    send_byte(8'hD1);
    idle(1);
    chk(rx_active == 1'b0, "R9 full descriptor ignored", 36'(rx_active), 36'h0);
    full_m = 0;
    send_byte(8'hD2); send_byte(8'hD3); send_byte(8'hD4);
    idle(2);
    chk(bd_ptr == 16'h0308, "R9 resume after full", 36'(bd_ptr), 36'h0308);

    // R10 illegal function code
    write_cfg(8'h17);
    chk(fc_fault == 1'b1, "R10 fault flag", 36'(fc_fault), 36'h1);
    send_byte(8'hE1); send_byte(8'hE2); send_byte(8'hE3);
    idle(2);
    chk(bd_ptr == 16'h0310, "R10 pointer still moves", 36'(bd_ptr), 36'h0310);
    write_cfg(8'h03);
    chk(fc_fault == 1'b0, "R10 fault clear", 36'(fc_fault), 36'h0);
    send_byte(8'hF1); send_byte(8'hF2); send_byte(8'hF3);
    idle(3);

    chk(expq.size() == 0, "R5 all writes seen", 36'(expq.size()), 36'h0);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule